// File: doc/BRIEF.md
# Match/capture timer with interrupt flags

This block is a counter peripheral built around a wide up-counter. In timer mode the counter advances once every PRESCALE+1 clocks. In counter mode it advances on the rising, falling or both edges of one external capture input, chosen through the mode register. Every input first passes through a two-flop synchronizer, and edges are found by comparing the synchronized value with its previous value.

A set of compare channels watches the value the counter is about to take. When a channel's compare value equals that next value, the channel raises its flag. If the channel has its clear-on-compare bit set, the counter returns to zero on that same advance. In counter mode that advance is the same input edge that produced the compare.

Capture channels copy the counter into a per-channel register on a configured input edge. All flags sit in one register that software clears by writing ones. A hardware set and a software clear in the same cycle are merged bit by bit, so no event is lost. The interrupt line is the OR of the flags gated by their enables. Software reaches every register through a simple single-cycle register bus. Writes take effect on the clock edge, and read data is combinational from the address.

Top module: `mc_timer`

Register addresses (word index on `bus_addr`): 0 control (bit 0 run, bit 1 hold-at-zero), 1 mode (bits 1:0 source: 0 prescaled clock, 1 rising, 2 falling, 3 both edges; bit 8 selects the capture input used as count source), 2 counter value, 3 prescale limit, 4 flags, 5 interrupt enables, 6 clear-on-compare per compare channel, 7 capture edge config (two bits per channel: low bit rising, high bit falling), 8..11 compare values, 16..17 capture values. Flag and enable bit i is compare channel i (bits 3:0), and bit 4+j is capture channel j. Unmapped addresses read as zero.

## Requirements
- R1: In timer mode, with run set and hold clear, the counter advances by one on every (PRESCALE+1)-th clock. The first advance comes on the (PRESCALE+1)-th edge after run is written.
- R2: In counter mode (source 1, 2 or 3), the counter advances on the rising, falling or both edges of the capture input picked by mode bit 8. An input change is counted on the third rising clock edge after it. Edges on the unselected input have no effect on the counter.
- R3: When an advance would give the counter a value equal to compare value i, flag bit i is set on that same clock edge. No flag bit rises without an event.
- R4: If clear-on-compare bit i is set and compare i fires, the counter becomes 0 on that same edge instead of taking the compare value.
- R5: Advancing from the all-ones value wraps the counter to 0.
- R6: A capture edge that matches the channel's configuration copies the counter value from before that edge into capture register j. On the same edge it sets flag bit 4+j.
- R7: Writing the flag register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: An event that coincides with a flag-register write always sets its own bit, even when the write clears that same bit. A clear of one bit never blocks a set of another bit.
- R9: The interrupt output is high exactly when some flag bit and its enable bit are both 1.
- R10: With run clear the counter and prescaler hold their values. With hold set the counter and prescaler are forced to 0.
- R11: A bus write to the counter address loads the counter on that edge, and the load takes precedence over any advance.
- R12: After reset every register reads as 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr` (combinational) |
| cap_in | input | NUM_CAP (2) | Asynchronous capture / count inputs |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a compare or capture event landing on the exact clock edge where software writes the flag register. The bench sets the prescale limit to zero and loads a known counter value, which makes the advance edge predictable. It then places the write-one-to-clear on that edge, once clearing the bit being set and once clearing a different bit. After that, a long random phase toggles the inputs and fires clears every few cycles. A behavioural model checks the read data and the interrupt on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_MODE   = 1;
    localparam int unsigned REG_COUNT  = 2;
    localparam int unsigned REG_PRESC  = 3;
    localparam int unsigned REG_FLAGS  = 4;
    localparam int unsigned REG_IRQEN  = 5;
    localparam int unsigned REG_MRST   = 6;
    localparam int unsigned REG_CAPCFG = 7;
    localparam int unsigned REG_MATCH0 = 8;
    localparam int unsigned REG_CAP0   = 16;
    localparam int unsigned MODE_SEL_LSB = 8;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } src_e;

    typedef struct packed {
        logic hold;
        logic run;
    } ctrl_t;

    function automatic logic src_hit(src_e s, logic r, logic f);
        case (s)
            SRC_RISE: return r;
            SRC_FALL: return f;
            SRC_BOTH: return r | f;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic cap_hit(logic [1:0] cfg, logic r, logic f);
        return (cfg[0] & r) | (cfg[1] & f);
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_ch
        // [0] first stage, [1] synchronized, [2] previous synchronized
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], pin[g]};
        end
        assign rise[g] =  sh[1] & ~sh[2];
        assign fall[g] = ~sh[1] &  sh[2];
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned NM    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic                     hold,
    input  src_e                     src,
    input  logic                     ext_rise,
    input  logic                     ext_fall,
    input  logic [CNT_W-1:0]         presc,
    input  logic                     load,
    input  logic [CNT_W-1:0]         load_val,
    input  logic [NM-1:0][CNT_W-1:0] match_val,
    input  logic [NM-1:0]            match_rst,
    output logic [CNT_W-1:0]         count,
    output logic                     tick,
    output logic [NM-1:0]            match_ev,
    output logic                     rst_hit
);
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] nxt;
    logic             pc_wrap;
    logic             adv_ok;

    assign pc_wrap = (pc_q == presc);
    assign adv_ok  = run & ~hold;
    assign nxt     = count + CNT_W'(1);

    always_comb begin
        if (src == SRC_CLK) tick = adv_ok & pc_wrap;
        else                tick = adv_ok & src_hit(src, ext_rise, ext_fall);
    end

    for (genvar i = 0; i < NM; i++) begin : g_cmp
        assign match_ev[i] = tick & (nxt == match_val[i]);
    end

    assign rst_hit = |(match_ev & match_rst);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (hold) count <= '0;
        else if (tick) count <= rst_hit ? '0 : nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || hold)
            pc_q <= '0;
        else if (run && src == SRC_CLK)
            pc_q <= pc_wrap ? '0 : pc_q + CNT_W'(1);
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned NC    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NC-1:0]            rise,
    input  logic [NC-1:0]            fall,
    input  logic [2*NC-1:0]          cfg,
    input  logic [CNT_W-1:0]         count,
    output logic [NC-1:0]            cap_ev,
    output logic [NC-1:0][CNT_W-1:0] cap_val
);
    for (genvar j = 0; j < NC; j++) begin : g_ev
        assign cap_ev[j] = cap_hit(cfg[2*j +: 2], rise[j], fall[j]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
        end else begin
            for (int j = 0; j < NC; j++)
                if (cap_ev[j]) cap_val[j] <= count;
        end
    end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
    parameter int unsigned NF = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] ev,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    // per bit: a set always wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | ev;
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/mc_timer.sv
module mc_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_MATCH = 4,
    parameter int unsigned NUM_CAP   = 2,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    input  logic [NUM_CAP-1:0]  cap_in,
    output logic                irq
);
    localparam int unsigned NF    = NUM_MATCH + NUM_CAP;
    localparam int unsigned SEL_W = (NUM_CAP > 1) ? $clog2(NUM_CAP) : 1;

    ctrl_t                          ctrl_q;
    src_e                           src_q;
    logic [SEL_W-1:0]               sel_q;
    logic [CNT_W-1:0]               presc_q;
    logic [NF-1:0]                  irq_en_q;
    logic [NUM_MATCH-1:0]           mrst_q;
    logic [2*NUM_CAP-1:0]           capcfg_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;

    logic [NUM_CAP-1:0]             rise, fall;
    logic                           ext_rise, ext_fall;
    logic [CNT_W-1:0]               count_q;
    logic                           tick;
    logic                           rst_hit;
    logic [NUM_MATCH-1:0]           match_ev;
    logic [NUM_CAP-1:0]             cap_ev;
    logic [NUM_CAP-1:0][CNT_W-1:0]  cap_val;
    logic [NF-1:0]                  ev_all, clr_mask, flags_q;
    logic                           cnt_load, run_en, hold_en;

    function automatic logic wr_at(int unsigned a);
        return bus_wr && (bus_addr == ADDR_W'(a));
    endfunction

    assign run_en   = ctrl_q.run;
    assign hold_en  = ctrl_q.hold;
    assign cnt_load = wr_at(REG_COUNT);
    assign clr_mask = wr_at(REG_FLAGS) ? bus_wdata[NF-1:0] : '0;
    assign ev_all   = {cap_ev, match_ev};

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            src_q    <= SRC_CLK;
            sel_q    <= '0;
            presc_q  <= '0;
            irq_en_q <= '0;
            mrst_q   <= '0;
            capcfg_q <= '0;
            match_q  <= '0;
        end else begin
            if (wr_at(REG_CTRL))   ctrl_q   <= ctrl_t'(bus_wdata[1:0]);
            if (wr_at(REG_MODE)) begin
                src_q <= src_e'(bus_wdata[1:0]);
                sel_q <= bus_wdata[MODE_SEL_LSB +: SEL_W];
            end
            if (wr_at(REG_PRESC))  presc_q  <= bus_wdata;
            if (wr_at(REG_IRQEN))  irq_en_q <= bus_wdata[NF-1:0];
            if (wr_at(REG_MRST))   mrst_q   <= bus_wdata[NUM_MATCH-1:0];
            if (wr_at(REG_CAPCFG)) capcfg_q <= bus_wdata[2*NUM_CAP-1:0];
            for (int i = 0; i < NUM_MATCH; i++)
                if (wr_at(REG_MATCH0 + i)) match_q[i] <= bus_wdata;
        end
    end

    tmr_edge_sync #(.WIDTH(NUM_CAP)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    // count-source input select; an out-of-range select yields no edges
    always_comb begin
        ext_rise = 1'b0;
        ext_fall = 1'b0;
        for (int i = 0; i < NUM_CAP; i++) begin
            if (sel_q == SEL_W'(i)) begin
                ext_rise = rise[i];
                ext_fall = fall[i];
            end
        end
    end

    tmr_count_core #(.CNT_W(CNT_W), .NM(NUM_MATCH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (run_en),
        .hold      (hold_en),
        .src       (src_q),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .presc     (presc_q),
        .load      (cnt_load),
        .load_val  (bus_wdata),
        .match_val (match_q),
        .match_rst (mrst_q),
        .count     (count_q),
        .tick      (tick),
        .match_ev  (match_ev),
        .rst_hit   (rst_hit)
    );

    tmr_capture #(.CNT_W(CNT_W), .NC(NUM_CAP)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .fall    (fall),
        .cfg     (capcfg_q),
        .count   (count_q),
        .cap_ev  (cap_ev),
        .cap_val (cap_val)
    );

    tmr_irq_flags #(.NF(NF)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev_all),
        .clr   (clr_mask),
        .en    (irq_en_q),
        .flags (flags_q),
        .irq   (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL):   bus_rdata = CNT_W'(ctrl_q);
            ADDR_W'(REG_MODE): begin
                bus_rdata[1:0] = src_q;
                bus_rdata[MODE_SEL_LSB +: SEL_W] = sel_q;
            end
            ADDR_W'(REG_COUNT):  bus_rdata = count_q;
            ADDR_W'(REG_PRESC):  bus_rdata = presc_q;
            ADDR_W'(REG_FLAGS):  bus_rdata = CNT_W'(flags_q);
            ADDR_W'(REG_IRQEN):  bus_rdata = CNT_W'(irq_en_q);
            ADDR_W'(REG_MRST):   bus_rdata = CNT_W'(mrst_q);
            ADDR_W'(REG_CAPCFG): bus_rdata = CNT_W'(capcfg_q);
            default: begin
                for (int i = 0; i < NUM_MATCH; i++)
                    if (bus_addr == ADDR_W'(REG_MATCH0 + i)) bus_rdata = match_q[i];
                for (int j = 0; j < NUM_CAP; j++)
                    if (bus_addr == ADDR_W'(REG_CAP0 + j)) bus_rdata = cap_val[j];
            end
        endcase
    end
endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned NM    = 4,
    parameter int unsigned NC    = 2,
    parameter int unsigned NF    = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NF-1:0]            flags,
    input logic [NF-1:0]            ev,
    input logic [NF-1:0]            clr,
    input logic [NF-1:0]            en,
    input logic                     irq,
    input logic [CNT_W-1:0]         count,
    input logic                     tick,
    input logic                     load,
    input logic                     hold,
    input logic                     run,
    input logic                     rst_hit,
    input logic [NC-1:0]            cap_ev,
    input logic [NC-1:0][CNT_W-1:0] cap_val
);
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)))
        else $error("event flag lost"); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~ev) != '0) |=> ((flags & $past(clr & ~ev)) == '0))
        else $error("written-one bit not cleared"); // R7

    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flags & ~$past(flags)) & ~$past(ev)) == '0))
        else $error("flag rose without event"); // R3

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq)
        else $error("irq with no flag"); // R9

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !hold && !rst_hit && count == '1) |=> (count == '0))
        else $error("no wrap to zero"); // R5

    AST_MATCH_RESET: assert property (@(posedge clk) disable iff (rst)
        (tick && rst_hit && !load) |=> (count == '0))
        else $error("compare reset missed"); // R4

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> (count == '0))
        else $error("hold did not zero counter"); // R10

    AST_STOPPED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold && !load) |=> $stable(count))
        else $error("stopped counter moved"); // R10

    for (genvar g = 0; g < NC; g++) begin : g_cap
        AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
            cap_ev[g] |=> (cap_val[g] == $past(count)))
            else $error("capture value wrong"); // R6
    end
endmodule

bind mc_timer mc_timer_chk #(
    .CNT_W (CNT_W),
    .NM    (NUM_MATCH),
    .NC    (NUM_CAP),
    .NF    (NF)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags_q),
    .ev      (ev_all),
    .clr     (clr_mask),
    .en      (irq_en_q),
    .irq     (irq),
    .count   (count_q),
    .tick    (tick),
    .load    (cnt_load),
    .hold    (hold_en),
    .run     (run_en),
    .rst_hit (rst_hit),
    .cap_ev  (cap_ev),
    .cap_val (cap_val)
);

// File: tb/tb_mc_timer.sv
module tb_mc_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mc_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_count, m_pc, m_pre;
    logic [1:0]  m_ctrl, m_src;
    logic        m_sel;
    logic [5:0]  m_flags, m_en;
    logic [3:0]  m_mrst, m_capcfg;
    logic [31:0] m_match [4];
    logic [31:0] m_capv  [2];
    logic [1:0]  s1, s2, s3;

    always @(posedge clk) begin : model
        logic [1:0]  rise, fall;
        logic        run, tk, hit, r, f;
        logic [31:0] nv, n_count, n_pc;
        logic [5:0]  ev, clr;
        if (rst) begin
            m_count = 0; m_pc = 0; m_pre = 0; m_ctrl = 0; m_src = 0; m_sel = 0;
            m_flags = 0; m_en = 0; m_mrst = 0; m_capcfg = 0;
            for (int i = 0; i < 4; i++) m_match[i] = 0;
            for (int j = 0; j < 2; j++) m_capv[j] = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            rise = s2 & ~s3;
            fall = ~s2 & s3;
            run  = m_ctrl[0] && !m_ctrl[1];
            if (m_src == 0) tk = run && (m_pc == m_pre);
            else begin
                r  = rise[m_sel];
                f  = fall[m_sel];
                tk = run && ((m_src == 1 && r) || (m_src == 2 && f) || (m_src == 3 && (r || f)));
            end
            nv  = m_count + 1;
            ev  = 0;
            hit = 0;
            for (int i = 0; i < 4; i++)
                if (tk && nv == m_match[i]) begin
                    ev[i] = 1;
                    if (m_mrst[i]) hit = 1;
                end
            for (int j = 0; j < 2; j++)
                if ((m_capcfg[2*j] && rise[j]) || (m_capcfg[2*j+1] && fall[j])) begin
                    ev[4+j] = 1;
                    m_capv[j] = m_count;
                end
            clr = (bus_wr && bus_addr == 4) ? bus_wdata[5:0] : 6'd0;
            n_count = m_count;
            if (bus_wr && bus_addr == 2) n_count = bus_wdata;
            else if (m_ctrl[1])          n_count = 0;
            else if (tk)                 n_count = hit ? 32'd0 : nv;
            n_pc = m_pc;
            if (m_ctrl[1])                 n_pc = 0;
            else if (run && m_src == 0)    n_pc = (m_pc == m_pre) ? 32'd0 : m_pc + 1;
            m_count = n_count;
            m_pc    = n_pc;
            m_flags = (m_flags & ~clr) | ev;
            if (bus_wr) begin
                case (bus_addr)
                    5'd0: m_ctrl = bus_wdata[1:0];
                    5'd1: begin m_src = bus_wdata[1:0]; m_sel = bus_wdata[8]; end
                    5'd3: m_pre = bus_wdata;
                    5'd5: m_en = bus_wdata[5:0];
                    5'd6: m_mrst = bus_wdata[3:0];
                    5'd7: m_capcfg = bus_wdata[3:0];
                    5'd8, 5'd9, 5'd10, 5'd11: m_match[bus_addr - 8] = bus_wdata;
                    default: ;
                endcase
            end
            s3 = s2; s2 = s1; s1 = cap_in;
        end
    end

    function automatic logic [31:0] m_view(logic [4:0] a);
        case (a)
            5'd0:  return {30'd0, m_ctrl};
            5'd1:  return {23'd0, m_sel, 6'd0, m_src};
            5'd2:  return m_count;
            5'd3:  return m_pre;
            5'd4:  return {26'd0, m_flags};
            5'd5:  return {26'd0, m_en};
            5'd6:  return {28'd0, m_mrst};
            5'd7:  return {28'd0, m_capcfg};
            5'd8, 5'd9, 5'd10, 5'd11: return m_match[a - 8];
            5'd16: return m_capv[0];
            5'd17: return m_capv[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a)
            5'd0:  return "R10";
            5'd1:  return "R2";
            5'd2:  return "R1 R4 R5 R11";
            5'd3:  return "R1";
            5'd4:  return "R7 R8";
            5'd5:  return "R9";
            5'd6:  return "R4";
            5'd7, 5'd16, 5'd17: return "R6";
            5'd8, 5'd9, 5'd10, 5'd11: return "R3";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // per-clock comparison, a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (cmp_on) begin
            chk($sformatf("cycle read addr %0d %s", bus_addr, tag_of(bus_addr)),
                bus_rdata, m_view(bus_addr));
            chk("cycle irq R9", {31'd0, irq}, {31'd0, |(m_flags & m_en)});
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int j);
        cap_in[j] = 1'b1;
        idle(4);
        cap_in[j] = 1'b0;
        idle(4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        @(negedge clk);
        cmp_on = 1'b1;
        idle(2);
        rst = 1'b0;

        // R12 reset state
        rd(0, v);  chk("R12 ctrl after reset", v, 0);
        rd(2, v);  chk("R12 count after reset", v, 0);
        rd(4, v);  chk("R12 flags after reset", v, 0);
        rd(16, v); chk("R12 capture after reset", v, 0);
        chk("R12 irq after reset", {31'd0, irq}, 0);

        // R11 load, R5 wrap (compare values are all 0, so wrap also fires compares: R3)
        wr(2, 32'hFFFF_FFFF);
        rd(2, v);  chk("R11 counter load", v, 32'hFFFF_FFFF);
        wr(0, 1);
        idle(1);
        rd(2, v);  chk("R5 wrap to zero", v, 0);
        rd(4, v);  chk("R3 compare flags on wrap", v, 32'h0F);
        wr(0, 0);
        rd(2, v);  chk("R10 last advance", v, 1);
        idle(3);
        rd(2, v);  chk("R10 stopped counter holds", v, 1);

        // R7 write-one-to-clear
        wr(4, 32'h5);
        rd(4, v);  chk("R7 clear written ones", v, 32'hA);
        wr(4, 32'h0);
        rd(4, v);  chk("R7 zero write has no effect", v, 32'hA);
        wr(4, 32'h3F);
        rd(4, v);  chk("R7 clear all", v, 0);

        // R1 prescaled timer
        wr(2, 0);
        wr(3, 2);
        wr(0, 1);
        idle(9);
        rd(2, v);  chk("R1 three advances in nine clocks", v, 3);
        idle(2);
        rd(2, v);  chk("R1 no advance mid-period", v, 3);
        idle(1);
        rd(2, v);  chk("R1 advance at period end", v, 4);

        // R10 hold
        wr(0, 3);
        idle(2);
        rd(2, v);  chk("R10 hold forces zero", v, 0);
        wr(0, 0);

        // R3/R4 compare with reset, R9 interrupt
        wr(3, 0);
        wr(9, 4);
        wr(6, 32'h2);
        wr(5, 32'h2);
        wr(2, 0);
        wr(0, 1);
        idle(3);
        rd(2, v);  chk("R4 count below compare", v, 3);
        idle(1);
        rd(2, v);  chk("R4 reset on compare edge", v, 0);
        rd(4, v);  chk("R3 compare flag set", v, 32'h2);
        chk("R9 irq with enabled flag", {31'd0, irq}, 1);

        // R8 set and clear of the same bit on the same edge
        idle(3);
        wr(4, 32'h2);
        rd(4, v);  chk("R8 set beats same-bit clear", v, 32'h2);
        // R8 clear of bit 1 while compare 0 fires
        wr(8, 2);
        wr(4, 32'h2);
        rd(4, v);  chk("R8 clear does not block other set", v, 32'h1);
        chk("R9 irq masked by enable", {31'd0, irq}, 0);
        wr(5, 32'h1);
        chk("R9 irq follows enable", {31'd0, irq}, 1);

        wr(0, 0);
        wr(4, 32'h3F);
        wr(5, 0);
        wr(6, 0);
        wr(8, 0);
        wr(9, 0);

        // R2 counter mode with compare reset on the same edge (R4)
        wr(2, 0);
        wr(10, 3);
        wr(6, 32'h4);
        wr(1, 32'h001);
        wr(0, 1);
        pulse(0); pulse(0);
        rd(2, v);  chk("R2 rising edges counted", v, 2);
        pulse(0);
        rd(2, v);  chk("R4 counter-mode reset on matching edge", v, 0);
        rd(4, v);  chk("R3 counter-mode compare flag", v, 32'h4);
        wr(4, 32'h3F);
        wr(1, 32'h002);
        pulse(0);
        rd(2, v);  chk("R2 falling edge counted", v, 1);
        wr(1, 32'h003);
        pulse(0);
        rd(2, v);  chk("R2 both edges, reset at compare", v, 0);
        wr(1, 32'h101);
        pulse(0);
        rd(2, v);  chk("R2 unselected input ignored", v, 0);
        pulse(1);
        rd(2, v);  chk("R2 selected input counted", v, 1);

        // R6 capture
        wr(0, 0);
        wr(4, 32'h3F);
        wr(2, 32'h1234);
        wr(7, 32'h1);
        pulse(0);
        rd(16, v); chk("R6 capture on rising edge", v, 32'h1234);
        rd(4, v);  chk("R6 capture flag", v, 32'h10);
        wr(7, 32'h8);
        wr(2, 32'h777);
        pulse(1);
        rd(17, v); chk("R6 capture on falling edge", v, 32'h777);
        rd(16, v); chk("R6 other channel unchanged", v, 32'h1234);
        rd(4, v);  chk("R6 both capture flags", v, 32'h30);

        // random phase, compared every clock by the model
        wr(4, 32'h3F);
        wr(1, 0);
        wr(3, 1);
        wr(8, 7);
        wr(9, 3);
        wr(10, 5);
        wr(6, 32'h1);
        wr(5, 32'h3F);
        wr(7, 32'hF);
        wr(0, 1);
        for (int k = 0; k < 2000; k++) begin
            if ($urandom_range(3) == 0) cap_in[$urandom_range(1)] ^= 1'b1;
            case ($urandom_range(9))
                0, 1: begin bus_wr = 1'b1; bus_addr = 4; bus_wdata = $urandom_range(63); end
                2: begin
                    bus_wr = 1'b1; bus_addr = 1;
                    bus_wdata = {23'd0, 1'($urandom_range(1)), 6'd0, 2'($urandom_range(3))};
                end
                3: begin bus_wr = 1'b1; bus_addr = 2; bus_wdata = $urandom_range(6); end
                default: begin
                    bus_wr = 1'b0;
                    bus_addr = 5'($urandom_range(17));
                end
            endcase
            @(negedge clk);
        end
        bus_wr = 1'b0;
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule